// File: doc/BRIEF.md
# Phase-Accumulator Dithered PWM

This block makes a pulse-width-modulated bit from a wide phase accumulator rather than from a free-running counter. On every clock a programmable step is added to the accumulator, and the sum wraps modulo 2^ACC_W. The step therefore sets how often the ramp rolls over, which fixes the PWM frequency. The ramp is compared against a duty threshold of the same width, and the result is registered onto the output pin.

The threshold has as many bits as the ramp. The average duty can therefore be set far more finely than the number of clocks in one period would permit. The price is that the output edge moves by up to one clock from one period to the next. This average precision holds only when the step does not divide the modulus evenly, so that successive periods sample different phases. The block is for loads that respond to the average, such as heaters, LED drivers or a PWM DAC with an external filter. Software writes the step and the duty words, and the block runs freely.

Top module: `phase_pwm`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the output is 0. Reset clears the ramp, the step and the threshold to zero.
- R2: On each clock where the captured step is nonzero, the ramp advances by the step.
- R3: The output is registered. On the clock after a ramp value is used, the output is 0 if that ramp value was below the captured threshold, and 1 if it was at or above the threshold (unsigned comparison).
- R4: The step and duty inputs are captured on one clock edge and are first used at the next edge.
- R5: A captured step of zero freezes both the ramp and the output. While the step stays zero, changes on the duty input have no effect on the output.
- R6: Two threshold extremes behave as follows. A threshold of 0 gives a constant 1 while the ramp runs. A threshold of 2^ACC_W-1 gives a 1 only when the ramp equals all ones.
- R7: The step and threshold are held constant over a window of W clocks, and the window spans P ramp wraps. The count of high clocks then differs from W*(2^ACC_W - duty)/2^ACC_W by at most P+2.
- R8: The ramp wraps modulo 2^ACC_W and drops the carry. An all-ones step therefore makes the ramp decrement by one on each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| stepIn | input | ACC_W (24) | Ramp increment per clock, unsigned |
| dutyIn | input | ACC_W (24) | Duty threshold, unsigned |
| pwmOut | output | 1 | Registered PWM bit |

## Verification
A value placed on stepIn or dutyIn at edge k is captured at edge k and used to update the ramp at edge k+1. The output change that results appears at edge k+1 and depends on the ramp value from before that edge. The bench keeps its own arithmetic model of the ramp and advances it at each rising edge in exactly this order. It compares the output with the model at every falling edge. Inputs are driven only at falling edges. The average-duty windows count high clocks at those same falling-edge samples and set the total against the ideal fraction, allowing a margin for each wrap.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  localparam int DEFAULT_ACC_W = 24;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // ramp and output may update this clock
  } pwm_strobe_t;
endpackage

// File: rtl/phase_pwm_ctrl.sv
module phase_pwm_ctrl
  import phase_pwm_pkg::*;
#(
  parameter int ACC_W = DEFAULT_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] stepIn,
  input  logic [ACC_W-1:0] dutyIn,
  output logic [ACC_W-1:0] stepVal,
  output logic [ACC_W-1:0] dutyVal,
  output pwm_strobe_t      strb
);
  localparam logic [ACC_W-1:0] ZERO_W = '0;

  // capture inputs: usable from the following edge (R4)
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stepVal <= ZERO_W;
      dutyVal <= ZERO_W;
    end else begin
      stepVal <= stepIn;
      dutyVal <= dutyIn;
    end
  end

  // zero step freezes everything downstream (R5)
  always_comb begin
    strb.advance = (stepVal != ZERO_W);
  end

  // R4: captured step follows the input one edge later
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    $past(stepIn) == ZERO_W |-> !strb.advance);
endmodule

// File: rtl/phase_pwm_dp.sv
module phase_pwm_dp
  import phase_pwm_pkg::*;
#(
  parameter int ACC_W = DEFAULT_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] stepVal,
  input  logic [ACC_W-1:0] dutyVal,
  input  pwm_strobe_t      strb,
  output logic             pwmOut
);
  localparam logic [ACC_W-1:0] ZERO_W = '0;
  localparam logic [ACC_W-1:0] ONES_W = '1;

  logic [ACC_W-1:0] ramp;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ramp   <= ZERO_W;
      pwmOut <= 1'b0;
    end else if (strb.advance) begin
      ramp   <= ramp + stepVal;          // natural modulo wrap (R8)
      pwmOut <= (ramp >= dutyVal);       // registered compare (R3)
    end
  end

  // R3: below threshold gives low on the next clock
  p_low_r3: assert property (@(posedge clk) disable iff (rst)
    strb.advance && (ramp < dutyVal) |=> !pwmOut);
  // R3: at or above threshold gives high on the next clock
  p_high_r3: assert property (@(posedge clk) disable iff (rst)
    strb.advance && (ramp >= dutyVal) |=> pwmOut);
  // R5: frozen ramp and output while the step is zero
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> $stable(ramp) && $stable(pwmOut));
  // R6: zero threshold means high while running
  p_fullon_r6: assert property (@(posedge clk) disable iff (rst)
    strb.advance && dutyVal == ZERO_W |=> pwmOut);
  // R6: all-ones threshold only passes at all-ones ramp
  p_top_r6: assert property (@(posedge clk) disable iff (rst)
    strb.advance && dutyVal == ONES_W && ramp != ONES_W |=> !pwmOut);
  // R8: a ramp that went down must have carried out of the top bit
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    $past(strb.advance) && (ramp < $past(ramp)) |-> ($past(ramp) > ~$past(stepVal)));
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
#(
  parameter int ACC_W = DEFAULT_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] stepIn,
  input  logic [ACC_W-1:0] dutyIn,
  output logic             pwmOut
);
  logic [ACC_W-1:0] stepVal;
  logic [ACC_W-1:0] dutyVal;
  pwm_strobe_t      strb;

  phase_pwm_ctrl #(.ACC_W(ACC_W)) i_ctrl (
    .clk(clk), .rst(rst), .stepIn(stepIn), .dutyIn(dutyIn),
    .stepVal(stepVal), .dutyVal(dutyVal), .strb(strb)
  );

  phase_pwm_dp #(.ACC_W(ACC_W)) i_dp (
    .clk(clk), .rst(rst), .stepVal(stepVal), .dutyVal(dutyVal),
    .strb(strb), .pwmOut(pwmOut)
  );

  // R1: output low on the first clock after reset
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> !pwmOut);
endmodule

// File: tb/test_phase_pwm.sv
module test_phase_pwm;
  localparam int  CLK_PERIOD = 10;
  localparam int  ACC_W = 24;
  localparam longint MODV = 64'd1 << ACC_W;
  localparam longint MASK = MODV - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ACC_W-1:0] stepIn = '0;
  logic [ACC_W-1:0] dutyIn = '0;
  logic pwmOut;

  int checks = 0;
  int fails = 0;

  longint mRamp = 0, mStep = 0, mDuty = 0;
  bit mOut = 1'b0;

  phase_pwm #(.ACC_W(ACC_W)) i_phase_pwm (
    .clk(clk), .rst(rst), .stepIn(stepIn), .dutyIn(dutyIn), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Arithmetic model of the ramp, applied at the rising edge.
  task automatic modelEdge();
    if (mStep != 0) begin
      mOut  = (mRamp >= mDuty);
      mRamp = (mRamp + mStep) & MASK;
    end
    mStep = longint'(stepIn);
    mDuty = longint'(dutyIn);
  endtask

  // Drive at falling edges, compare with the model at every falling edge.
  task automatic run(input string req, input int n, input longint s, input longint d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, longint'(pwmOut), longint'(mOut));
      stepIn = s[ACC_W-1:0];
      dutyIn = d[ACC_W-1:0];
      @(posedge clk);
      modelEdge();
    end
  endtask

  task automatic average(input string req, input int w, input longint s, input longint d);
    longint startRamp;
    longint wraps;
    int highs;
    real ideal, diff;
    run(req, 4, s, d);
    startRamp = mRamp;
    highs = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
      @(posedge clk);
      modelEdge();
    end
    wraps = (startRamp + longint'(w) * s) / MODV;
    ideal = real'(w) * real'(MODV - d) / real'(MODV);
    diff  = real'(highs) - ideal;
    if (diff < 0.0) diff = -diff;
    checks++;
    if (diff > real'(wraps + 2)) begin
      fails++;
      $display("FAIL %s: actual %0d highs expected %0f within %0d", req, highs, ideal, wraps + 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 during reset", longint'(pwmOut), 0);
    rst = 1'b0;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check("R1 after release", longint'(pwmOut), 0);

    // zero step: nothing moves, duty changes ignored
    run("R5 idle zero step", 6, 0, 5);

    // R4: first step write, the ramp starts one edge later
    run("R4 latency", 3, 24'h100000, 24'h800000);
    // R2/R3 exact sixteenth-step ramp
    run("R2 R3 sixteenth step", 64, 24'h100000, 24'h800000);
    // R4 duty change mid-run
    run("R4 duty change", 40, 24'h100000, 24'h300000);

    // R5 freeze with duty toggling between the extremes
    run("R5 freeze", 2, 0, 24'h300000);
    for (int i = 0; i < 10; i++) begin
      logic held;
      @(negedge clk);
      held = pwmOut;
      check("R5 freeze model", longint'(pwmOut), longint'(mOut));
      stepIn = '0;
      dutyIn = (i % 2 == 0) ? 24'h000000 : 24'hFFFFFF;
      @(posedge clk);
      modelEdge();
      @(negedge clk);
      check("R5 held level", longint'(pwmOut), longint'(held));
      @(posedge clk);
      modelEdge();
    end

    // R6 extremes
    run("R6 zero threshold", 40, 24'h2AAAAB, 0);
    run("R6 top threshold", 20, 24'h000001, 24'hFFFFFF);

    // R8 all-ones step decrements through the wrap
    run("R8 wrap decrement", 40, 24'hFFFFFF, 24'hFFFFFE);
    run("R8 near-full step", 40, 24'hF00001, 24'h7FFFFF);

    // R7 averages over many wraps
    average("R7 average A", 4000, 24'h123457, 24'h4CCCCD);
    average("R7 average B", 8000, 24'h00A3D7, 24'h19999A);
    average("R7 average C", 6000, 24'h0F0F0F, 24'hE66666);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule